// File: doc/BRIEF.md
# Paged Receive Buffer Ring Manager

This block places the bytes of incoming Ethernet frames into a circular receive area of local buffer RAM that is divided into 256-byte pages. Software programs three page numbers:

- a first page of the ring;
- a stop page that lies just past the ring's last page;
- a guard page that marks the oldest page not yet read by the host.

The block turns the byte stream into RAM write commands. It moves from page to page and wraps from the last ring page back to the first. It never writes into the guard page.

Each stored frame begins with a four-byte record at offset 0 of its first page. The frame data starts at offset 4. The record is written only after the last byte has arrived, once the length and the following page are known. When a frame is good, the current-page register moves to the page after the frame's last page, and a completion interrupt pulses. A frame that is flagged bad at its end leaves the current page where it was, so the next frame reuses the same space. A frame that would run into the guard page is cut off with an overflow pulse.

An optional early mode raises a page interrupt each time a frame still arriving needs a fresh page. A running byte count of the frame in progress is always visible as a low byte and a high byte.

The frame source must leave at least four idle cycles after each last byte, because the record is written during those cycles. The guard page must differ from the current page whenever a frame starts.

Top module: `rxr_ring_mgr`

## Requirements
- R1: While rst_n is low at a clock edge, cur_pg loads ring_first_pg. After that edge ram_we, ovf, irq_page and irq_done are 0, and both count bytes are 0.
- R2: The first byte of a frame (byte_vld with byte_sof while no frame is open) is written at address {cur_pg, 8'd4}. Each following accepted byte goes to the next offset of the same page. Every write appears on the RAM port in the cycle after the byte is sampled.
- R3: A byte that follows a byte stored at offset 255 goes to offset 0 of the next page. The page after ring_stop_pg-1 is ring_first_pg.
- R4: After the last byte of a good frame (byte_eof with frame_ok=1), four writes follow in the next four cycles, to offsets 0,1,2,3 of the frame's first page. They carry, in that order: the status byte 8'h01, the next-page number, the low byte of the data length, and the high byte of the data length. The data length is the number of data bytes stored.
- R5: cur_pg changes only in the cycle of the fourth record write of a good frame. In that cycle it takes the page after the frame's last data page, and irq_done is 1 for exactly that cycle.
- R6: A frame that ends with frame_ok=0 writes no record, leaves cur_pg unchanged and raises no irq_done.
- R7: When a byte needs a new page and that page equals guard_pg, the byte is not written and ovf is 1 for one cycle. The rest of the frame up to its last byte is not written, no record is written and cur_pg is unchanged.
- R8: When early_en is 1 in the cycle a byte needs a new page, irq_page is 1 together with that byte's write at offset 0. With early_en 0, or on the first page of a frame, irq_page stays 0.
- R9: {rx_count_hi, rx_count_lo} is the number of bytes accepted in the current or latest frame. It changes with each data write and holds after the frame until the next frame start.
- R10: On a page change refused as in R7, irq_page stays 0 even when early_en is 1.
- R11: Bytes presented while no frame is open, and without byte_sof, cause no write and leave the count and cur_pg unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_first_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page just past the last ring page |
| guard_pg | input | 8 | Oldest unread page; never written |
| byte_vld | input | 1 | A frame byte is present |
| byte_dat | input | 8 | Frame byte |
| byte_sof | input | 1 | Byte is the first of a frame |
| byte_eof | input | 1 | Byte is the last of a frame |
| frame_ok | input | 1 | With byte_eof: the frame is good |
| early_en | input | 1 | Enables the per-page interrupt |
| ram_we | output | 1 | Buffer RAM write strobe |
| ram_addr | output | 16 | Buffer RAM byte address {page, offset} |
| ram_wdata | output | 8 | Buffer RAM write data |
| cur_pg | output | 8 | Start page for the next frame |
| rx_count_lo | output | 8 | Running byte count, low byte |
| rx_count_hi | output | 8 | Running byte count, high byte |
| ovf | output | 1 | One-cycle pulse when a frame is cut off at the guard page |
| irq_page | output | 1 | One-cycle early page interrupt |
| irq_done | output | 1 | One-cycle good-frame completion pulse |

## Verification
A page change can fall in the same cycle as both the early page interrupt and the guard-page refusal. This is provoked by a long frame, sent with early_en high, whose second page is the guard page. The run passes only if ovf pulses with no write and no irq_page, if no byte or record follows, and if cur_pg and the count stay at their cut-off values. The last byte of a frame can also coincide with the end of a page. A frame that exactly fills its first page checks that the next-page field and cur_pg still move to the page after it, and that no early interrupt is raised.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the receive ring manager.
// Assumes: byte-wide buffer RAM and a fixed four-field frame record.
package rxr_pkg;
    // Phase of the frame being handled.
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,   // no frame open
        RX_FILL = 2'd1,   // storing data bytes
        RX_SKIP = 2'd2,   // cut off, waiting for the last byte
        RX_HEAD = 2'd3    // writing the frame record
    } rx_phase_e;

    // Size of the frame record at the start of the first page.
    localparam int HDR_BYTES = 4;
    // Status value written for an intact frame.
    localparam logic [7:0] STAT_INTACT = 8'h01;
endpackage

// File: rtl/rxr_page_step.sv
`timescale 1ns/1ps
// Page successor within the ring, plus the guard-page compare.
// Assumes: first_pg < stop_pg and pg lies inside [first_pg, stop_pg).
module rxr_page_step #(
    parameter int PG_W = 8
) (
    input  logic [PG_W-1:0] pg,
    input  logic [PG_W-1:0] first_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [PG_W-1:0] guard_pg,
    output logic [PG_W-1:0] nxt_pg,
    output logic            hits_guard
);
    logic [PG_W-1:0] inc_pg;

    // Next page, wrapping at the stop page, and whether it is protected.
    always_comb begin
        inc_pg     = pg + PG_W'(1);
        nxt_pg     = (inc_pg == stop_pg) ? first_pg : inc_pg;
        hits_guard = (nxt_pg == guard_pg);
    end
endmodule

// File: rtl/rxr_hdr_fmt.sv
`timescale 1ns/1ps
// Selects one byte of the frame record: status, next page, length low/high.
// Assumes: page numbers fit in one byte and the count is at least 16 bits wide.
module rxr_hdr_fmt
    import rxr_pkg::*;
#(
    parameter int PG_W  = 8,
    parameter int CNT_W = 16
) (
    input  logic [1:0]       idx,
    input  logic [PG_W-1:0]  nxt_pg,
    input  logic [CNT_W-1:0] len,
    output logic [7:0]       hdr_byte
);
    // Record byte for the given index.
    always_comb begin
        case (idx)
            2'd0:    hdr_byte = STAT_INTACT;
            2'd1:    hdr_byte = 8'(nxt_pg);
            2'd2:    hdr_byte = len[7:0];
            default: hdr_byte = 8'(len >> 8);
        endcase
    end
endmodule

// File: rtl/rxr_ring_mgr.sv
`timescale 1ns/1ps
// Receive ring manager: places frame bytes into 256-byte pages of a
// circular buffer, refuses to enter the guard page, writes a four-byte
// record at the start of each good frame and advances the current page.
// Assumes: at least four idle cycles after each last byte, and guard_pg
// differs from cur_pg whenever a frame starts.
module rxr_ring_mgr
    import rxr_pkg::*;
#(
    parameter int PG_W      = 8,
    parameter int OFF_W     = 8,
    parameter int CNT_W     = 16,
    parameter bit HAS_EARLY = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PG_W-1:0]        ring_first_pg,
    input  logic [PG_W-1:0]        ring_stop_pg,
    input  logic [PG_W-1:0]        guard_pg,
    input  logic                   byte_vld,
    input  logic [7:0]             byte_dat,
    input  logic                   byte_sof,
    input  logic                   byte_eof,
    input  logic                   frame_ok,
    input  logic                   early_en,
    output logic                   ram_we,
    output logic [PG_W+OFF_W-1:0]  ram_addr,
    output logic [7:0]             ram_wdata,
    output logic [PG_W-1:0]        cur_pg,
    output logic [7:0]             rx_count_lo,
    output logic [7:0]             rx_count_hi,
    output logic                   ovf,
    output logic                   irq_page,
    output logic                   irq_done
);
    localparam int              ADDR_W    = PG_W + OFF_W;
    localparam logic [OFF_W-1:0] DATA_OFF  = OFF_W'(HDR_BYTES);
    localparam logic [OFF_W-1:0] DATA_OFF1 = OFF_W'(HDR_BYTES + 1);
    localparam logic [1:0]      LAST_HIDX = 2'(HDR_BYTES - 1);

    rx_phase_e          phase;
    logic [PG_W-1:0]    cur_q;
    logic [PG_W-1:0]    wr_pg;
    logic [OFF_W-1:0]   wr_off;
    logic [PG_W-1:0]    start_pg;
    logic [CNT_W-1:0]   cnt;
    logic [1:0]         hidx;
    logic               we_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [7:0]         wdata_q;
    logic               ovf_q;
    logic               irqp_q;
    logic               irqd_q;

    logic [PG_W-1:0]    step_nxt;
    logic               step_hit;
    logic [7:0]         hdr_byte;
    logic               need_pg;
    logic               early_ok;

    // Successor of the page last written, for both data and record.
    rxr_page_step #(.PG_W(PG_W)) u_step (
        .pg         (wr_pg),
        .first_pg   (ring_first_pg),
        .stop_pg    (ring_stop_pg),
        .guard_pg   (guard_pg),
        .nxt_pg     (step_nxt),
        .hits_guard (step_hit)
    );

    // Record byte for the current record index.
    rxr_hdr_fmt #(.PG_W(PG_W), .CNT_W(CNT_W)) u_hdr (
        .idx      (hidx),
        .nxt_pg   (step_nxt),
        .len      (cnt),
        .hdr_byte (hdr_byte)
    );

    // Early page interrupt is present only when the variant asks for it.
    generate
        if (HAS_EARLY) begin : g_early
            assign early_ok = early_en;
        end else begin : g_no_early
            assign early_ok = 1'b0;
        end
    endgenerate

    // A zero offset inside an open frame means the current page is full.
    assign need_pg = (wr_off == '0);

    // Frame phase, write cursor, byte count and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= RX_IDLE;
            cur_q    <= ring_first_pg;
            wr_pg    <= '0;
            wr_off   <= '0;
            start_pg <= '0;
            cnt      <= '0;
            hidx     <= '0;
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            ovf_q    <= 1'b0;
            irqp_q   <= 1'b0;
            irqd_q   <= 1'b0;
        end else begin
            we_q   <= 1'b0;
            ovf_q  <= 1'b0;
            irqp_q <= 1'b0;
            irqd_q <= 1'b0;
            case (phase)
                RX_IDLE: begin
                    if (byte_vld && byte_sof) begin
                        we_q     <= 1'b1;
                        addr_q   <= {cur_q, DATA_OFF};
                        wdata_q  <= byte_dat;
                        start_pg <= cur_q;
                        wr_pg    <= cur_q;
                        wr_off   <= DATA_OFF1;
                        cnt      <= CNT_W'(1);
                        hidx     <= '0;
                        if (byte_eof) begin
                            phase <= frame_ok ? RX_HEAD : RX_IDLE;
                        end else begin
                            phase <= RX_FILL;
                        end
                    end
                end
                RX_FILL: begin
                    if (byte_vld) begin
                        if (need_pg && step_hit) begin
                            ovf_q <= 1'b1;
                            phase <= byte_eof ? RX_IDLE : RX_SKIP;
                        end else begin
                            we_q    <= 1'b1;
                            wdata_q <= byte_dat;
                            cnt     <= cnt + CNT_W'(1);
                            wr_off  <= wr_off + OFF_W'(1);
                            if (need_pg) begin
                                wr_pg  <= step_nxt;
                                addr_q <= {step_nxt, {OFF_W{1'b0}}};
                                irqp_q <= early_ok;
                            end else begin
                                addr_q <= {wr_pg, wr_off};
                            end
                            if (byte_eof) begin
                                phase <= frame_ok ? RX_HEAD : RX_IDLE;
                            end
                        end
                    end
                end
                RX_SKIP: begin
                    if (byte_vld && byte_eof) begin
                        phase <= RX_IDLE;
                    end
                end
                RX_HEAD: begin
                    we_q    <= 1'b1;
                    addr_q  <= {start_pg, OFF_W'(hidx)};
                    wdata_q <= hdr_byte;
                    hidx    <= hidx + 2'd1;
                    if (hidx == LAST_HIDX) begin
                        cur_q  <= step_nxt;
                        irqd_q <= 1'b1;
                        phase  <= RX_IDLE;
                    end
                end
                default: phase <= RX_IDLE;
            endcase
        end
    end

    // Registered outputs.
    assign ram_we      = we_q;
    assign ram_addr    = addr_q;
    assign ram_wdata   = wdata_q;
    assign cur_pg      = cur_q;
    assign rx_count_lo = cnt[7:0];
    assign rx_count_hi = 8'(cnt >> 8);
    assign ovf         = ovf_q;
    assign irq_page    = irqp_q;
    assign irq_done    = irqd_q;
endmodule

// File: rtl/rxr_ring_chk.sv
`timescale 1ns/1ps
// Checker for the receive ring manager, bound to its ports.
// Assumes: ring_first_pg is steady while reset is held.
module rxr_ring_chk #(
    parameter int PG_W  = 8,
    parameter int OFF_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ram_we,
    input logic [PG_W+OFF_W-1:0] ram_addr,
    input logic [PG_W-1:0]       cur_pg,
    input logic                  ovf,
    input logic                  irq_page,
    input logic                  irq_done
);
    // R5: completion comes with the last record write (offset 3).
    a_r5_done_with_last_record: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (ram_we && ram_addr[OFF_W-1:0] == OFF_W'(3)));

    // R5: the current page moves only on completion.
    a_r5_page_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_pg != $past(cur_pg)) |-> irq_done);

    // R7: a refused page change writes nothing.
    a_r7_no_write_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !ram_we);

    // R10: a refused page change raises no page interrupt.
    a_r10_no_page_irq_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !irq_page);

    // R8: a page interrupt comes with a write at offset 0.
    a_r8_page_irq_at_page_base: assert property (@(posedge clk) disable iff (!rst_n)
        irq_page |-> (ram_we && ram_addr[OFF_W-1:0] == '0));
endmodule

bind rxr_ring_mgr rxr_ring_chk #(.PG_W(PG_W), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .cur_pg   (cur_pg),
    .ovf      (ovf),
    .irq_page (irq_page),
    .irq_done (irq_done)
);

// File: tb/rxr_ring_mgr_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the frame driver predicts every RAM write and pushes
// it into a queue; a monitor pops and compares each write as it appears.
module rxr_ring_mgr_test;
    localparam logic [7:0] FIRST = 8'h10;
    localparam logic [7:0] STOP  = 8'h16;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        pg;
        logic        done;
        logic [3:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  guard;
    logic        byte_vld, byte_sof, byte_eof, frame_ok, early_en;
    logic [7:0]  byte_dat;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  cur_pg, rx_count_lo, rx_count_hi;
    logic        ovf, irq_page, irq_done;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          ovf_seen = 0;
    int          ovf_exp = 0;
    logic [7:0]  m_cur;

    always #4 clk = ~clk;

    rxr_ring_mgr uut (
        .clk(clk), .rst_n(rst_n),
        .ring_first_pg(FIRST), .ring_stop_pg(STOP), .guard_pg(guard),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_sof(byte_sof),
        .byte_eof(byte_eof), .frame_ok(frame_ok), .early_en(early_en),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .cur_pg(cur_pg), .rx_count_lo(rx_count_lo), .rx_count_hi(rx_count_hi),
        .ovf(ovf), .irq_page(irq_page), .irq_done(irq_done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ring_next(input logic [7:0] p);
        return (p + 8'd1 == STOP) ? FIRST : p + 8'd1;
    endfunction

    // Monitor: compare every RAM write with the head of the queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (ovf) ovf_seen++;
            if (ovf && irq_page) check(1'b0, "R10", "irq_page with ovf", 1, 0);
            if (ram_we) begin
                if (q.size() == 0) begin
                    check(1'b0, "R11", "unexpected write addr", int'(ram_addr), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    checks++;
                    if (ram_addr !== e.addr || ram_wdata !== e.data ||
                        irq_page !== e.pg || irq_done !== e.done) begin
                        errors++;
                        $display("FAIL R%0d write a/d/pg/done %h/%h/%b/%b expected %h/%h/%b/%b",
                                 e.req, ram_addr, ram_wdata, irq_page, irq_done,
                                 e.addr, e.data, e.pg, e.done);
                    end
                end
            end else if (irq_page || irq_done) begin
                check(1'b0, "R8", "interrupt without write", 1, 0);
            end
        end
    end

    // Driver: predict writes (R2 R3 R4 R5 R7 R8 R10), then send the bytes.
    task automatic send_frame(input int len, input bit ok, input bit early,
                              input logic [7:0] seed);
        logic [7:0]  pg;
        logic [7:0]  off;
        logic [7:0]  np;
        logic [15:0] acc;
        bit          cut;
        bit          pgi;
        pg = m_cur; off = 8'd4; acc = '0; cut = 1'b0;
        for (int i = 0; i < len; i++) begin
            pgi = 1'b0;
            if (!cut && i > 0 && off == 8'd0) begin
                np = ring_next(pg);
                if (np == guard) begin
                    cut = 1'b1;            // R7 cut-off at guard page
                    ovf_exp++;
                end else begin
                    pg  = np;              // R3 page change
                    pgi = early;           // R8 early interrupt
                end
            end
            if (!cut) begin
                q.push_back('{{pg, off}, 8'(i) ^ seed, pgi, 1'b0,
                              pgi ? 4'd8 : (i == 0 ? 4'd2 : 4'd3)});
                off = off + 8'd1;
                acc = acc + 16'd1;
            end
        end
        if (!cut && ok) begin
            np = ring_next(pg);            // R4 record, R5 completion
            q.push_back('{{m_cur, 8'd0}, 8'h01,     1'b0, 1'b0, 4'd4});
            q.push_back('{{m_cur, 8'd1}, np,        1'b0, 1'b0, 4'd4});
            q.push_back('{{m_cur, 8'd2}, acc[7:0],  1'b0, 1'b0, 4'd4});
            q.push_back('{{m_cur, 8'd3}, acc[15:8], 1'b0, 1'b1, 4'd5});
            m_cur = np;
        end
        early_en = early;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_dat = 8'(i) ^ seed;
            byte_sof = (i == 0);
            byte_eof = (i == len - 1);
            frame_ok = (i == len - 1) ? ok : 1'b0;
        end
        @(negedge clk);
        byte_vld = 1'b0; byte_sof = 1'b0; byte_eof = 1'b0; frame_ok = 1'b0;
        repeat (8) @(negedge clk);
        check(q.size() == 0, "R4", "writes still pending", q.size(), 0);
        check(cur_pg == m_cur, ok && !cut ? "R5" : "R6", "cur_pg", cur_pg, m_cur);
        check({rx_count_hi, rx_count_lo} == acc, "R9", "byte count",
              {rx_count_hi, rx_count_lo}, acc);
        check(ovf_seen == ovf_exp, "R7", "overflow pulses", ovf_seen, ovf_exp);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Test sequence.
    initial begin
        rst_n = 1'b0; guard = 8'h15;
        byte_vld = 1'b0; byte_sof = 1'b0; byte_eof = 1'b0;
        frame_ok = 1'b0; early_en = 1'b0; byte_dat = '0;
        m_cur = FIRST;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cur_pg == FIRST, "R1", "cur_pg after reset", cur_pg, FIRST);
        check(!ram_we && !ovf && !irq_page && !irq_done, "R1", "strobes after reset",
              {ram_we, ovf, irq_page, irq_done}, 0);
        check({rx_count_hi, rx_count_lo} == 16'd0, "R1", "count after reset",
              {rx_count_hi, rx_count_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        send_frame(20, 1'b1, 1'b0, 8'h3C);     // R2 R4 R5: short good frame
        send_frame(30, 1'b0, 1'b1, 8'h55);     // R6: rejected frame
        send_frame(600, 1'b1, 1'b1, 8'hA1);    // R3 R8: three pages, early on
        guard = 8'h12;
        send_frame(300, 1'b1, 1'b0, 8'h0F);    // R3: wrap to first page, R8 off
        guard = 8'h11;
        send_frame(700, 1'b1, 1'b1, 8'h77);    // R7 R10: cut off at guard

        // R11: stray bytes with no frame open
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_vld = 1'b1; byte_dat = 8'(i); byte_sof = 1'b0; byte_eof = 1'b0;
        end
        @(negedge clk);
        byte_vld = 1'b0;
        repeat (4) @(negedge clk);
        check({rx_count_hi, rx_count_lo} == 16'd252, "R11", "count after stray bytes",
              {rx_count_hi, rx_count_lo}, 252);
        check(cur_pg == m_cur, "R11", "cur_pg after stray bytes", cur_pg, m_cur);

        guard = 8'h13;
        send_frame(1, 1'b1, 1'b1, 8'hE2);      // R4: single byte, sof and eof together
        send_frame(252, 1'b1, 1'b1, 8'h19);    // R5 R8: exactly one full page

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule